// File: doc/BRIEF.md
# Analog multiplexer scan sequencer

This block drives the three timing lines that walk an external multichannel analog front end through its first eight channels. A step line advances the front end's input multiplexer, a convert line starts the converter, and an active-low return line sends the multiplexer back to its first channel. Everything runs from one system clock. The high-phase width of the step waveform comes from a static configuration input, and a run enable starts and stops the sequence.

Time is organised into frames of eight equal slots. In each of the first seven slots the step line goes high for the first half of the slot and low for the second, and the convert line is its complement. The eighth slot carries no step pulse. Instead the return line goes low for exactly one step-high width, and both step and convert are forced low during that time. A one-cycle sample strobe marks the start of every slot, which gives downstream readout logic a fixed point at which to collect a sample. The configured width is captured only when a frame starts, so a new setting takes effect cleanly at the next frame.

Top module: `mux_scan_seq`

## Requirements
- R1: While running with captured half width H (1 to 65535), each slot lasts 2*H clocks and the step line is high during phase counts 0 to H-1 of slots 0 to 6 and low for the rest of the slot.
- R2: Whenever the return line is high, the convert line equals the inverse of the step line.
- R3: A frame is 8 slots, numbered 0 to 7 in time order. The return line is low only during phase counts 0 to H-1 of slot 7, and the next frame begins at slot 0 straight after slot 7.
- R4: An uninterrupted frame contains exactly seven rising edges of the step line, and slot 7 contains none.
- R5: Whenever the return line is low, both the step line and the convert line are low.
- R6: The sample strobe is high for exactly one clock at phase count 0 of every slot while running, including slot 7.
- R7: When the run enable is sampled low, all four outputs are low from the next cycle. When it is sampled high again, the next cycle is slot 0 at phase count 0, with the step, return and strobe lines high.
- R8: While the synchronous reset is sampled high, all outputs are low from the next cycle, and the return line stays low until the first frame starts.
- R9: The half-width input is captured only when running starts and when a new frame begins. A change at any other time has no effect on the current frame.
- R10: A half-width input of 0 is treated as 1, giving a 2-clock slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| srst_i | input | 1 | Synchronous reset, active high |
| run_i | input | 1 | Run enable |
| half_period_i | input | 16 | Step-high width in clocks (0 is treated as 1) |
| mux_step_o | output | 1 | Multiplexer advance line |
| adc_cnv_o | output | 1 | Conversion start line |
| mux_rst_n_o | output | 1 | Active-low multiplexer return line |
| sample_stb_o | output | 1 | One-cycle strobe at the start of every slot |

## Verification
A wrong slot index shows up within one slot time: the return line drops in the wrong slot, or a frame counts six or eight step edges instead of seven. A wrong phase count or a wrongly captured width shifts the step edges and the strobe within 2*H clocks, and the per-cycle comparison reports this at the first affected clock. A fault in the run or reset gating appears one cycle after the control input changes, as an output left high or a restart that does not begin at slot 0.

// File: rtl/mux_scan_pkg.sv
package mux_scan_pkg;

  localparam int unsigned HP_W = 16;

  typedef logic [HP_W-1:0] half_t;
  typedef logic [HP_W:0]   phase_t;

  // Width actually used for a slot half; zero is promoted to one.
  function automatic half_t eff_half(input half_t h);
    return (h == '0) ? half_t'(1) : h;
  endfunction

  // Last phase count of a slot whose high half is h clocks wide.
  function automatic phase_t last_phase(input half_t h);
    return {h, 1'b0} - phase_t'(1);
  endfunction

  // True while the phase count lies in the first (high) half of the slot.
  function automatic logic in_high_half(input phase_t p, input half_t h);
    return p < {1'b0, h};
  endfunction

endpackage

// File: rtl/scan_phase_timer.sv
module scan_phase_timer
  import mux_scan_pkg::*;
(
  input  logic   clk_i,
  input  logic   srst_i,
  input  logic   run_i,
  input  half_t  half_in,
  input  logic   frame_end,
  output logic   active,
  output phase_t phase,
  output half_t  half_q,
  output logic   phase_wrap
);

  assign phase_wrap = active && (phase == last_phase(half_q));

  always_ff @(posedge clk_i) begin
    if (srst_i) begin
      active <= 1'b0;
      phase  <= '0;
      half_q <= half_t'(1);
    end else if (!run_i) begin
      active <= 1'b0;
      phase  <= '0;
    end else if (!active) begin
      active <= 1'b1;
      phase  <= '0;
      half_q <= eff_half(half_in);
    end else if (phase_wrap) begin
      phase <= '0;
      if (frame_end) half_q <= eff_half(half_in);
    end else begin
      phase <= phase + phase_t'(1);
    end
  end

endmodule

// File: rtl/scan_slot_counter.sv
module scan_slot_counter #(
  parameter int unsigned SLOTS = 8
) (
  input  logic clk_i,
  input  logic srst_i,
  input  logic run_i,
  input  logic active,
  input  logic phase_wrap,
  output logic slot_last,
  output logic frame_end
);

  localparam int unsigned SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

  logic [SLOT_W-1:0] slot;
  logic [SLOT_W-1:0] slot_next;

  assign slot_last = (slot == LAST_SLOT);
  assign frame_end = phase_wrap && slot_last;

  generate
    if ((1 << SLOT_W) == SLOTS) begin : g_pow2
      assign slot_next = slot + SLOT_W'(1);
    end else begin : g_cmp
      assign slot_next = slot_last ? '0 : slot + SLOT_W'(1);
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (srst_i || !run_i || !active) begin
      slot <= '0;
    end else if (phase_wrap) begin
      slot <= slot_next;
    end
  end

endmodule

// File: rtl/scan_wave_shaper.sv
module scan_wave_shaper
  import mux_scan_pkg::*;
(
  input  logic   active,
  input  phase_t phase,
  input  half_t  half_q,
  input  logic   slot_last,
  output logic   step_o,
  output logic   cnv_o,
  output logic   rst_n_o,
  output logic   stb_o
);

  logic high_half;
  logic blank;

  always_comb begin
    high_half = in_high_half(phase, half_q);
    blank     = slot_last && high_half;
    rst_n_o   = active && !blank;
    step_o    = rst_n_o && high_half;
    cnv_o     = rst_n_o && !high_half;
    stb_o     = active && (phase == '0);
  end

endmodule

// File: rtl/mux_scan_seq.sv
module mux_scan_seq
  import mux_scan_pkg::*;
#(
  parameter int unsigned SLOTS = 8
) (
  input  logic            clk_i,
  input  logic            srst_i,
  input  logic            run_i,
  input  logic [HP_W-1:0] half_period_i,
  output logic            mux_step_o,
  output logic            adc_cnv_o,
  output logic            mux_rst_n_o,
  output logic            sample_stb_o
);

  logic   active;
  phase_t phase;
  half_t  half_q;
  logic   phase_wrap;
  logic   slot_last;
  logic   frame_end;

  scan_phase_timer u_timer (
    .clk_i      (clk_i),
    .srst_i     (srst_i),
    .run_i      (run_i),
    .half_in    (half_period_i),
    .frame_end  (frame_end),
    .active     (active),
    .phase      (phase),
    .half_q     (half_q),
    .phase_wrap (phase_wrap)
  );

  scan_slot_counter #(.SLOTS(SLOTS)) u_slots (
    .clk_i      (clk_i),
    .srst_i     (srst_i),
    .run_i      (run_i),
    .active     (active),
    .phase_wrap (phase_wrap),
    .slot_last  (slot_last),
    .frame_end  (frame_end)
  );

  scan_wave_shaper u_shape (
    .active    (active),
    .phase     (phase),
    .half_q    (half_q),
    .slot_last (slot_last),
    .step_o    (mux_step_o),
    .cnv_o     (adc_cnv_o),
    .rst_n_o   (mux_rst_n_o),
    .stb_o     (sample_stb_o)
  );

endmodule

// File: rtl/mux_scan_checker.sv
module mux_scan_checker #(
  parameter int unsigned PULSES = 7
) (
  input logic clk_i,
  input logic srst_i,
  input logic run_i,
  input logic mux_step_o,
  input logic adc_cnv_o,
  input logic mux_rst_n_o,
  input logic sample_stb_o,
  input logic phase_wrap,
  input logic frame_end
);

  logic [7:0] rise_cnt;
  logic       step_q;

  always_ff @(posedge clk_i) begin
    step_q <= mux_step_o;
    if (srst_i || !mux_rst_n_o) begin
      rise_cnt <= '0;
    end else if (mux_step_o && !step_q && rise_cnt != 8'hFF) begin
      rise_cnt <= rise_cnt + 8'd1;
    end
  end

  p_blank_r5: assert property (@(posedge clk_i) disable iff (srst_i)
    !mux_rst_n_o |-> (!mux_step_o && !adc_cnv_o));

  p_cnv_compl_r2: assert property (@(posedge clk_i) disable iff (srst_i)
    mux_rst_n_o |-> (adc_cnv_o == !mux_step_o));

  p_stb_single_r6: assert property (@(posedge clk_i) disable iff (srst_i)
    sample_stb_o |=> !sample_stb_o);

  p_wrap_stb_r6: assert property (@(posedge clk_i) disable iff (srst_i)
    (phase_wrap && run_i) |=> sample_stb_o);

  p_new_frame_r3: assert property (@(posedge clk_i) disable iff (srst_i)
    (frame_end && run_i) |=> (mux_step_o && mux_rst_n_o));

  p_halt_r7: assert property (@(posedge clk_i) disable iff (srst_i)
    !run_i |=> (!mux_rst_n_o && !mux_step_o && !adc_cnv_o && !sample_stb_o));

  p_seven_steps_r4: assert property (@(posedge clk_i) disable iff (srst_i)
    ($fell(mux_rst_n_o) && $past(run_i) && !$past(srst_i))
      |-> (rise_cnt == 8'(PULSES)));

endmodule

bind mux_scan_seq mux_scan_checker #(.PULSES(SLOTS - 1)) u_chk (
  .clk_i        (clk_i),
  .srst_i       (srst_i),
  .run_i        (run_i),
  .mux_step_o   (mux_step_o),
  .adc_cnv_o    (adc_cnv_o),
  .mux_rst_n_o  (mux_rst_n_o),
  .sample_stb_o (sample_stb_o),
  .phase_wrap   (phase_wrap),
  .frame_end    (frame_end)
);

// File: tb/tb_mux_scan_seq.sv
module tb_mux_scan_seq;

  localparam int unsigned SLOTS = 8;

  logic        clk = 1'b0;
  logic        srst_i = 1'b1;
  logic        run_i = 1'b0;
  logic [15:0] half_period_i = 16'd4;
  logic        mux_step_o, adc_cnv_o, mux_rst_n_o, sample_stb_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  mux_scan_seq #(.SLOTS(SLOTS)) dut (
    .clk_i         (clk),
    .srst_i        (srst_i),
    .run_i         (run_i),
    .half_period_i (half_period_i),
    .mux_step_o    (mux_step_o),
    .adc_cnv_o     (adc_cnv_o),
    .mux_rst_n_o   (mux_rst_n_o),
    .sample_stb_o  (sample_stb_o)
  );

  // Reference state: position inside the frame and the width in force.
  bit          m_act = 0;
  bit          m_srst = 1;
  bit          m_from0 = 0;
  bit          m_chg = 0;
  int unsigned m_pos = 0;
  int unsigned m_hf = 1;
  int unsigned m_raw = 1;
  int unsigned rise_cnt = 0;
  bit          prev_step = 0;
  bit          frame_full = 0;

  function automatic int unsigned clamp_half(input int unsigned h);
    return (h == 0) ? 1 : h;
  endfunction

  task automatic check1(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string tag_for(input string base);
    if (!m_act) return m_srst ? "R8" : "R7";
    if (m_from0) return "R10";
    if (m_chg) return "R9";
    return base;
  endfunction

  task automatic check_outputs();
    int unsigned slot, ph;
    bit e_rst, e_step, e_cnv, e_stb;
    slot   = m_pos / (2 * m_hf);
    ph     = m_pos % (2 * m_hf);
    e_rst  = m_act && !((slot == SLOTS - 1) && (ph < m_hf));
    e_step = e_rst && (ph < m_hf);
    e_cnv  = e_rst && (ph >= m_hf);
    e_stb  = m_act && (ph == 0);
    check1(tag_for("R1"), mux_step_o, e_step);
    check1(tag_for("R2"), adc_cnv_o, e_cnv);
    check1(tag_for("R3"), mux_rst_n_o, e_rst);
    check1(tag_for("R6"), sample_stb_o, e_stb);
    if (!e_rst) check1("R5", mux_step_o | adc_cnv_o, 1'b0);
    // R4: count step rises over each complete frame
    if (!m_act) frame_full = 0;
    if (m_act && m_pos == 0) begin
      if (frame_full) begin
        checks++;
        if (rise_cnt != SLOTS - 1) begin
          errors++;
          $display("FAIL R4: actual %0d expected %0d step rises", rise_cnt, SLOTS - 1);
        end
      end
      rise_cnt   = 0;
      frame_full = 1;
    end
    if (mux_step_o && !prev_step) rise_cnt++;
    prev_step = mux_step_o;
  endtask

  task automatic load_half(input logic [15:0] h);
    m_raw   = h;
    m_hf    = clamp_half(h);
    m_from0 = (h == 0);
    m_chg   = 0;
  endtask

  task automatic model_edge(input bit s, input bit r, input logic [15:0] h);
    if (s) begin
      m_act = 0; m_pos = 0; m_srst = 1;
    end else if (!r) begin
      m_act = 0; m_pos = 0; m_srst = 0;
    end else if (!m_act) begin
      m_act = 1; m_pos = 0; m_srst = 0;
      load_half(h);
    end else begin
      m_pos++;
      if (m_pos == SLOTS * 2 * m_hf) begin
        m_pos = 0;
        load_half(h);
      end
    end
    if (m_act && (int'(h) != int'(m_raw))) m_chg = 1;
  endtask

  // Called at a falling edge: check, drive, advance model, wait.
  task automatic tick(input bit s, input bit r, input logic [15:0] h);
    check_outputs();
    srst_i = s;
    run_i = r;
    half_period_i = h;
    model_edge(s, r, h);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [15:0] hp;
    bit r;
    void'($urandom(32'd1234));
    @(negedge clk);
    // R8: reset state
    repeat (4) tick(1'b1, 1'b0, 16'd4);
    check1("R8", mux_rst_n_o, 1'b0);
    check1("R8", mux_step_o | adc_cnv_o | sample_stb_o, 1'b0);
    // R1/R3/R4: three full frames with H=3
    repeat (3 * 16 * 3 + 2) tick(1'b0, 1'b1, 16'd3);
    // R7: halt, then restart with width 0 (R10)
    tick(1'b0, 1'b0, 16'd3);
    check1("R7", mux_rst_n_o | mux_step_o | adc_cnv_o | sample_stb_o, 1'b0);
    tick(1'b0, 1'b1, 16'd0);
    check1("R7", mux_step_o & mux_rst_n_o & sample_stb_o, 1'b1);
    check1("R10", adc_cnv_o, 1'b0);
    repeat (3 * 16 + 1) tick(1'b0, 1'b1, 16'd0);
    // R9: width changes mid-frame, applied only at the next frame
    repeat (5) tick(1'b0, 1'b1, 16'd2);
    repeat (40) tick(1'b0, 1'b1, 16'd5);
    repeat (200) tick(1'b0, 1'b1, 16'd5);
    // R8 mid-run, then release
    repeat (2) tick(1'b1, 1'b1, 16'd5);
    check1("R8", mux_rst_n_o | mux_step_o | sample_stb_o, 1'b0);
    // Constrained random phase
    hp = 16'd3;
    r = 1'b1;
    for (int i = 0; i < 20000; i++) begin
      int unsigned pick;
      pick = $urandom_range(999);
      if (pick < 30) hp = 16'($urandom_range(6));
      if (pick >= 100 && pick < 110) r = 1'b0;
      else if (!r && pick < 500) r = 1'b1;
      tick(pick >= 990, r, hp);
    end
    check_outputs();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule